// File: doc/BRIEF.md
# Bidirectional Pixel Readout Sequencer

This block is the digital controller of a line-sensor readout with a parameterised row of pixels (64 by default). A start input that is high on a clock edge while the block is idle begins a cycle: every pixel's value is frozen by a one-cycle hold strobe, and then the pixels are placed on the output path one at a time. Each pixel is selected for exactly one clock. The scan direction is chosen by a direction input. Odd and even pixels feed two separate bus lines, so a bus-select output tells a downstream multiplexer which line carries the current pixel. A cascade output marks the final pixel so that a chained sensor can begin its own scan.

When the start input is still high during the last pixel of a scan, the block spends one cycle pulsing an integration-reset output and then goes straight into a new hold and scan. This gives continuous operation. When the start input is low at that point, the block returns to idle with every output low.

The controller has four named states. IDLE waits for the start input. HOLD lasts one cycle and freezes the pixel values. SCAN steps through the pixels. RESTART lasts one cycle and resets the integrators. The transitions are: IDLE to HOLD on start high, HOLD to SCAN always, SCAN to SCAN while pixels remain, SCAN to RESTART at the last pixel when start is high, SCAN to IDLE at the last pixel when start is low, and RESTART to HOLD always.

Top module: `pixscan_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises with start_i low, pix_sel_o is all zero and hold_o, bus_odd_o, int_rst_o and cascade_o are 0.
- R2: A rising clock edge in IDLE with start_i high makes hold_o 1 for exactly the following cycle. No pixel is selected in that cycle, and the first pixel select appears in the cycle after it.
- R3: If dir_dn_i is 0 in the HOLD cycle, pix_sel_o is one-hot at bit 0, 1, 2 … NUM_PIX-1 in consecutive cycles.
- R4: If dir_dn_i is 1 in the HOLD cycle, pix_sel_o is one-hot at bit NUM_PIX-1, NUM_PIX-2 … 0 in consecutive cycles.
- R5: During SCAN exactly one bit of pix_sel_o is set. In all other states it is zero.
- R6: bus_odd_o is 1 exactly when the selected pixel index is odd, and it is 0 when no pixel is selected.
- R7: cascade_o is 1 for exactly one cycle per scan, in the cycle where the last pixel of the scan direction is selected (NUM_PIX-1 ascending, 0 descending).
- R8: If start_i is high in the last-pixel cycle, int_rst_o is 1 for the next cycle (RESTART), and that cycle is followed by a HOLD cycle and a new scan.
- R9: If start_i is low in the last-pixel cycle, the block returns to IDLE with all outputs 0. start_i has no effect during HOLD, RESTART, or any SCAN cycle except the last one.
- R10: dir_dn_i is sampled only in the HOLD cycle. A change during a scan does not alter that scan's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start / keep-running request |
| dir_dn_i | input | 1 | Scan direction: 0 ascending, 1 descending |
| pix_sel_o | output | NUM_PIX | One-hot pixel select |
| hold_o | output | 1 | One-cycle hold strobe before a scan |
| bus_odd_o | output | 1 | Output multiplexer select: 1 = odd bus line |
| int_rst_o | output | 1 | One-cycle integrator reset on automatic restart |
| cascade_o | output | 1 | Token to the next chained sensor on the last pixel |

## Verification
The bench runs three patterns. The first is a single ascending scan started by a one-cycle start pulse, with a stray start pulse in mid-scan. It separates a clean return to IDLE from a scan that is wrongly restarted or extended. The second holds start high with a descending direction, so back-to-back scans exercise RESTART, the integrator pulse and the reversed order. The third flips the direction in the middle of a running scan and shows that only the next scan changes order. The pixel index, bus parity and cascade position all differ between ascending and descending scans, so a wrong shift direction, start point or parity seed shows up within a few cycles.

// File: rtl/pixscan_pkg.sv
package pixscan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_HOLD    = 2'd1,
        ST_SCAN    = 2'd2,
        ST_RESTART = 2'd3
    } scan_state_t;

    typedef struct packed {
        logic clear;
        logic load;
        logic load_dn;
        logic shift;
        logic shift_dn;
    } chain_cmd_t;

endpackage

// File: rtl/pixscan_chain.sv
module pixscan_chain #(
    parameter int NUM_PIX = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  pixscan_pkg::chain_cmd_t   cmd,
    output logic [NUM_PIX-1:0]        sel
);
    logic [NUM_PIX-1:0] sel_q;
    logic [NUM_PIX-1:0] sel_d;

    for (genvar i = 0; i < NUM_PIX; i++) begin : g_bit
        logic below;
        logic above;
        if (i == 0) begin : g_lo
            assign below = 1'b0;
        end else begin : g_lo_n
            assign below = sel_q[i-1];
        end
        if (i == NUM_PIX - 1) begin : g_hi
            assign above = 1'b0;
        end else begin : g_hi_n
            assign above = sel_q[i+1];
        end

        always_comb begin
            if (cmd.clear) begin
                sel_d[i] = 1'b0;
            end else if (cmd.load) begin
                sel_d[i] = cmd.load_dn ? (i == NUM_PIX - 1) : (i == 0);
            end else if (cmd.shift) begin
                sel_d[i] = cmd.shift_dn ? above : below;
            end else begin
                sel_d[i] = sel_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign sel = sel_q;

endmodule

// File: rtl/pixscan_ctrl.sv
module pixscan_ctrl
    import pixscan_pkg::*;
#(
    parameter int NUM_PIX = 64,
    localparam int IDX_W = $clog2(NUM_PIX)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        dir_dn_i,
    output chain_cmd_t  cmd,
    output logic        scan_o,
    output logic        dir_q_o,
    output logic        hold_o,
    output logic        bus_odd_o,
    output logic        int_rst_o,
    output logic        cascade_o
);
    localparam logic [IDX_W-1:0] LAST_CNT = IDX_W'(NUM_PIX - 1);
    localparam logic TOP_ODD = 1'((NUM_PIX - 1) % 2);

    scan_state_t state_q, state_d;
    logic [IDX_W-1:0] cnt_q;
    logic dir_q;
    logic odd_q;
    logic at_last;

    assign at_last = (state_q == ST_SCAN) && (cnt_q == LAST_CNT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = ST_HOLD;
            ST_HOLD:    state_d = ST_SCAN;
            ST_SCAN:    if (at_last) state_d = start_i ? ST_RESTART : ST_IDLE;
            ST_RESTART: state_d = ST_HOLD;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            dir_q   <= 1'b0;
            odd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HOLD) begin
                cnt_q <= '0;
                dir_q <= dir_dn_i;
                odd_q <= dir_dn_i ? TOP_ODD : 1'b0;
            end else if (state_q == ST_SCAN && !at_last) begin
                cnt_q <= cnt_q + 1'b1;
                odd_q <= ~odd_q;
            end
        end
    end

    always_comb begin
        cmd       = '0;
        hold_o    = 1'b0;
        int_rst_o = 1'b0;
        bus_odd_o = 1'b0;
        cascade_o = 1'b0;
        scan_o    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HOLD: begin
                hold_o      = 1'b1;
                cmd.load    = 1'b1;
                cmd.load_dn = dir_dn_i;
            end
            ST_SCAN: begin
                scan_o       = 1'b1;
                bus_odd_o    = odd_q;
                cascade_o    = at_last;
                cmd.clear    = at_last;
                cmd.shift    = !at_last;
                cmd.shift_dn = dir_q;
            end
            ST_RESTART: int_rst_o = 1'b1;
            default: ;
        endcase
    end

    assign dir_q_o = dir_q;

    // R2: hold strobe lasts one cycle and is followed by the scan
    a_r2_hold_then_scan: assert property (@(posedge clk) disable iff (!rst_n)
        hold_o |=> (!hold_o && scan_o));

    // R8: restart pulse leads into a hold cycle
    a_r8_restart_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
        int_rst_o |=> hold_o);

    // R9: start input cannot cut a scan short before its last pixel
    a_r9_scan_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_o && !cascade_o) |=> scan_o);

    // R9: leaving the last pixel with start low goes idle
    a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cascade_o && !start_i) |=> (!scan_o && !hold_o && !int_rst_o));

endmodule

// File: rtl/pixscan_seq.sv
module pixscan_seq
    import pixscan_pkg::*;
#(
    parameter int NUM_PIX = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               dir_dn_i,
    output logic [NUM_PIX-1:0] pix_sel_o,
    output logic               hold_o,
    output logic               bus_odd_o,
    output logic               int_rst_o,
    output logic               cascade_o
);
    chain_cmd_t cmd;
    logic scan;
    logic dir_q;
    logic [NUM_PIX-1:0] odd_mask;

    pixscan_ctrl #(.NUM_PIX(NUM_PIX)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .dir_dn_i  (dir_dn_i),
        .cmd       (cmd),
        .scan_o    (scan),
        .dir_q_o   (dir_q),
        .hold_o    (hold_o),
        .bus_odd_o (bus_odd_o),
        .int_rst_o (int_rst_o),
        .cascade_o (cascade_o)
    );

    pixscan_chain #(.NUM_PIX(NUM_PIX)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .cmd   (cmd),
        .sel   (pix_sel_o)
    );

    for (genvar i = 0; i < NUM_PIX; i++) begin : g_mask
        assign odd_mask[i] = (i % 2) == 1;
    end

    // R5: select is one-hot during a scan and empty otherwise
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pix_sel_o) == (scan ? 1 : 0));

    // R6: bus select follows parity of the selected pixel
    a_r6_bus_parity: assert property (@(posedge clk) disable iff (!rst_n)
        scan |-> (bus_odd_o == (|(pix_sel_o & odd_mask))));

    // R7: cascade token coincides with the end pixel of the direction
    a_r7_cascade_end: assert property (@(posedge clk) disable iff (!rst_n)
        cascade_o |-> (dir_q ? pix_sel_o[0] : pix_sel_o[NUM_PIX-1]));

    // R10: latched direction stays fixed throughout a scan
    a_r10_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (scan && $past(scan)) |-> $stable(dir_q));

endmodule

// File: tb/pixscan_seq_tb.sv
module pixscan_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 64;
    localparam int WATCHDOG = 5000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic dir_dn_i = 1'b0;
    logic [NP-1:0] pix_sel_o;
    logic hold_o, bus_odd_o, int_rst_o, cascade_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model: 0 idle, 1 hold, 2 scan, 3 restart
    int mstate = 0;
    int midx = 0;
    int mdir = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixscan_seq #(.NUM_PIX(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_dn_i(dir_dn_i),
        .pix_sel_o(pix_sel_o), .hold_o(hold_o), .bus_odd_o(bus_odd_o),
        .int_rst_o(int_rst_o), .cascade_o(cascade_o)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            mstate = 0; midx = 0; mdir = 0;
        end else begin
            case (mstate)
                0: if (start_i) mstate = 1;
                1: begin
                    mstate = 2;
                    mdir = int'(dir_dn_i);
                    midx = (mdir != 0) ? NP - 1 : 0;
                end
                2: begin
                    if ((mdir != 0) ? (midx == 0) : (midx == NP - 1))
                        mstate = start_i ? 3 : 0;
                    else
                        midx = midx + ((mdir != 0) ? -1 : 1);
                end
                default: mstate = 1;
            endcase
        end
    end

    task automatic check(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            logic [NP-1:0] esel;
            logic scanning;
            logic last;
            string sreq;
            scanning = (mstate == 2);
            esel = '0;
            if (scanning) esel[midx] = 1'b1;
            last = scanning && ((mdir != 0) ? (midx == 0) : (midx == NP - 1));
            if (!rst_n) begin
                check("R1", pix_sel_o, '0);
                check("R1", NP'({hold_o, bus_odd_o, int_rst_o, cascade_o}), '0);
            end else begin
                if (!scanning)
                    sreq = "R9";
                else if (int'(dir_dn_i) != mdir)
                    sreq = "R10";
                else
                    sreq = (mdir != 0) ? "R4" : "R3";
                check(sreq, pix_sel_o, esel);
                check("R5", NP'($countones(pix_sel_o)), NP'(scanning ? 1 : 0));
                check("R2", NP'(hold_o), NP'(mstate == 1));
                check("R6", NP'(bus_odd_o), NP'(scanning && (midx % 2 == 1)));
                check("R8", NP'(int_rst_o), NP'(mstate == 3));
                check("R7", NP'(cascade_o), NP'(last));
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // pattern 1: single ascending scan, stray start mid-scan (R3, R9)
        start_i = 1'b1;
        cyc(1);
        start_i = 1'b0;
        cyc(30);
        start_i = 1'b1;
        cyc(1);
        start_i = 1'b0;
        cyc(45);
        // pattern 2: continuous descending scans (R4, R8)
        dir_dn_i = 1'b1;
        start_i = 1'b1;
        cyc(100);
        // pattern 3: flip direction mid-scan (R10), next scan ascends
        dir_dn_i = 1'b0;
        cyc(60);
        start_i = 1'b0;
        cyc(90);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired at %0t: actual running expected done", $time);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule